// File: doc/BRIEF.md
# Comma-Locked Word Aligner with Synchronization State Machine

This block sits behind a deserializer on one receive lane. Every clock it takes a 20-bit parallel word whose bit boundary is arbitrary. Each word carries two 10-bit line-code symbols. The block searches all twenty bit offsets for a programmable 10-bit comma symbol, in either of its running-disparity forms. It then fixes the word boundary at the offset where the comma was found and delivers the re-framed 20-bit word.

A three-state synchronization machine decides when the lane counts as framed. The states are loss, hunt and locked. Three programmable thresholds control it: how many commas at the locked boundary are needed to declare lock, how many bad words drop lock, and how many good words in a row remove one accumulated error. A pattern-detect flag marks every output word that holds a comma. A sync flag reports lock. A re-align request throws away the boundary and restarts the search. To cover several lanes, instantiate the block once per lane.

Top module: `wa_word_aligner`

## Requirements
- R1: While `rst_n` is low, `dout` is zero and `pat_det` and `sync_ok` are low.
- R2: A symbol counts as a comma when it equals `comma_pat` or the bitwise complement of `comma_pat`.
- R3: Bit 0 of `din` is the earliest bit received. The block forms a 40-bit history, with the current `din` in the upper half and the previous `din` in the lower half. In the loss state it takes the lowest offset k (0 to 19) at which history bits [k+9:k] hold a comma, and locks that k as the boundary. On every cycle, `dout` is loaded one clock later with history bits [k+19:k] at the locked k.
- R4: `pat_det` is registered together with `dout`. It is high exactly when `dout[9:0]` or `dout[19:10]` is a comma.
- R5: A comma found in the loss state counts as one and moves the machine to hunt, or straight to locked when `acq_thr` is at most 1. In hunt, each aligned word that holds a comma adds one. The machine enters locked when the count reaches `acq_thr`, and `sync_ok` is high exactly while it is locked. A threshold value of 0 acts as 1 for all three thresholds.
- R6: An invalid aligned word in hunt sends the machine back to loss, and the comma count restarts.
- R7: While locked, each invalid word raises the error count by one. The invalid word that brings the count to `lose_thr` sends the machine to loss, and `sync_ok` is low from the next clock.
- R8: While locked, a run of `fgv_thr` valid words in a row lowers the error count by one, but not below zero, and then the run restarts. An invalid word also restarts the run.
- R9: `realign` high at a clock edge sends the machine to loss and clears all counts. It overrides every other transition, so `sync_ok` is low after that edge.
- R10: In hunt and locked, commas at any other bit offset leave the boundary unchanged. Only the loss state picks a new boundary.
- R11: A 10-bit symbol is legal when it holds 4, 5 or 6 ones. A word is valid when both of its symbols are legal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel-word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 20 | Unaligned word from the deserializer, bit 0 earliest |
| comma_pat | input | 10 | Comma symbol to search for |
| acq_thr | input | 4 | Commas needed to declare lock |
| lose_thr | input | 4 | Error count that drops lock |
| fgv_thr | input | 4 | Consecutive valid words that remove one error |
| realign | input | 1 | Request to discard the boundary and search again |
| dout | output | 20 | Word re-framed at the locked boundary |
| pat_det | output | 1 | The current `dout` holds a comma in either symbol |
| sync_ok | output | 1 | The lane is locked |

## Verification
The hardest state to reach from the ports is a locked lane that sees commas at a foreign bit offset, while its error count rises and falls without ever reaching the loss threshold. The stimulus builds a bit-level stream from a queue of symbols. Once the lane is locked, it slips that stream by two bits, chosen so that no shifted window can look like a comma. It also raises the loss threshold for that stretch, so the boundary hold is seen in isolation. Later it interleaves bad words with runs of good ones, so that only the forgiveness rule keeps the lane locked. The symbols used sit right at the legality limits.

// File: rtl/wa_pkg.sv
package wa_pkg;

   typedef enum logic [1:0] {
      ST_LOSS   = 2'd0,
      ST_HUNT   = 2'd1,
      ST_LOCKED = 2'd2
   } wa_state_e;

endpackage

// File: rtl/wa_sym_match.sv
// Compares one symbol with the comma, optionally in both disparities.
module wa_sym_match #(
   parameter int SYM_W     = 10,
   parameter bit BOTH_DISP = 1'b1
) (
   input  logic [SYM_W-1:0] sym,
   input  logic [SYM_W-1:0] pat,
   output logic             match
);
   generate
      if (BOTH_DISP) begin : g_both
         assign match = (sym == pat) || (sym == ~pat);
      end else begin : g_single
         assign match = (sym == pat);
      end
   endgenerate
endmodule

// File: rtl/wa_sym_legal.sv
// Symbol legality by ones count: within one of half the symbol width.
module wa_sym_legal #(
   parameter int SYM_W = 10
) (
   input  logic [SYM_W-1:0] sym,
   output logic             legal
);
   localparam int ONES_W = $clog2(SYM_W + 1);
   localparam logic [ONES_W-1:0] ONES_LO = ONES_W'(SYM_W / 2 - 1);
   localparam logic [ONES_W-1:0] ONES_HI = ONES_W'(SYM_W / 2 + 1);

   logic [ONES_W-1:0] ones;

   always_comb begin
      ones = '0;
      for (int i = 0; i < SYM_W; i++) begin
         ones = ones + ONES_W'(sym[i]);
      end
   end

   assign legal = (ones >= ONES_LO) && (ones <= ONES_HI);
endmodule

// File: rtl/wa_comma_search.sv
// Scans every bit offset of the history for a comma; lowest offset wins.
module wa_comma_search #(
   parameter int DATA_W    = 20,
   parameter int SYM_W     = 10,
   parameter bit BOTH_DISP = 1'b1,
   parameter int OFF_W     = $clog2(DATA_W),
   parameter int SCAN_W    = DATA_W + SYM_W - 1
) (
   input  logic [SCAN_W-1:0] scan,
   input  logic [SYM_W-1:0]  pat,
   output logic              hit,
   output logic [OFF_W-1:0]  hit_off
);
   logic [DATA_W-1:0] hits;

   generate
      for (genvar k = 0; k < DATA_W; k++) begin : g_off
         wa_sym_match #(
            .SYM_W     (SYM_W),
            .BOTH_DISP (BOTH_DISP)
         ) u_match (
            .sym   (scan[k +: SYM_W]),
            .pat   (pat),
            .match (hits[k])
         );
      end
   endgenerate

   always_comb begin
      hit     = 1'b0;
      hit_off = '0;
      for (int k = DATA_W - 1; k >= 0; k--) begin
         if (hits[k]) begin
            hit     = 1'b1;
            hit_off = OFF_W'(k);
         end
      end
   end
endmodule

// File: rtl/wa_lane_pick.sv
// Frames the word at the locked offset and classifies its symbols.
module wa_lane_pick #(
   parameter int DATA_W    = 20,
   parameter int SYM_W     = 10,
   parameter bit BOTH_DISP = 1'b1,
   parameter int OFF_W     = $clog2(DATA_W),
   parameter int PICK_W    = 2 * DATA_W - 1
) (
   input  logic [PICK_W-1:0] hist,
   input  logic [OFF_W-1:0]  off,
   input  logic [SYM_W-1:0]  pat,
   output logic [DATA_W-1:0] aligned,
   output logic              word_valid,
   output logic              word_comma
);
   localparam int LANES = DATA_W / SYM_W;

   logic [LANES-1:0] lane_legal;
   logic [LANES-1:0] lane_comma;

   assign aligned = hist[off +: DATA_W];

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         wa_sym_legal #(
            .SYM_W (SYM_W)
         ) u_legal (
            .sym   (aligned[l*SYM_W +: SYM_W]),
            .legal (lane_legal[l])
         );
         wa_sym_match #(
            .SYM_W     (SYM_W),
            .BOTH_DISP (BOTH_DISP)
         ) u_match (
            .sym   (aligned[l*SYM_W +: SYM_W]),
            .pat   (pat),
            .match (lane_comma[l])
         );
      end
   endgenerate

   assign word_valid = &lane_legal;
   assign word_comma = |lane_comma;
endmodule

// File: rtl/wa_sync_fsm.sv
// Loss / hunt / locked machine with acquire, lose and forgive thresholds.
module wa_sync_fsm
   import wa_pkg::*;
#(
   parameter int OFF_W = 5,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             realign,
   input  logic             hit,
   input  logic [OFF_W-1:0] hit_off,
   input  logic             word_valid,
   input  logic             word_comma,
   input  logic [CNT_W-1:0] acq_thr,
   input  logic [CNT_W-1:0] lose_thr,
   input  logic [CNT_W-1:0] fgv_thr,
   output wa_state_e        state_q,
   output logic [OFF_W-1:0] lock_off,
   output logic [CNT_W-1:0] err_cnt
);
   localparam int CW1 = CNT_W + 1;

   wa_state_e        state_d;
   logic [OFF_W-1:0] off_d;
   logic [CNT_W-1:0] pcnt, pcnt_d, err_d, vcnt, vcnt_d;
   logic [CW1-1:0]   acq_e, lose_e, fgv_e;
   logic [CW1-1:0]   pcnt_inc, err_inc, vcnt_inc;

   function automatic logic [CW1-1:0] at_least_one(input logic [CNT_W-1:0] t);
      return (t == '0) ? CW1'(1) : {1'b0, t};
   endfunction

   assign acq_e    = at_least_one(acq_thr);
   assign lose_e   = at_least_one(lose_thr);
   assign fgv_e    = at_least_one(fgv_thr);
   assign pcnt_inc = {1'b0, pcnt} + CW1'(1);
   assign err_inc  = {1'b0, err_cnt} + CW1'(1);
   assign vcnt_inc = {1'b0, vcnt} + CW1'(1);

   always_comb begin
      state_d = state_q;
      off_d   = lock_off;
      pcnt_d  = pcnt;
      err_d   = err_cnt;
      vcnt_d  = vcnt;
      if (realign) begin
         state_d = ST_LOSS;
         pcnt_d  = '0;
         err_d   = '0;
         vcnt_d  = '0;
      end else begin
         case (state_q)
            ST_LOSS: begin
               if (hit) begin
                  off_d   = hit_off;
                  pcnt_d  = CNT_W'(1);
                  err_d   = '0;
                  vcnt_d  = '0;
                  state_d = (acq_e <= CW1'(1)) ? ST_LOCKED : ST_HUNT;
               end
            end
            ST_HUNT: begin
               if (!word_valid) begin
                  state_d = ST_LOSS;
                  pcnt_d  = '0;
               end else if (word_comma) begin
                  pcnt_d = pcnt_inc[CNT_W-1:0];
                  if (pcnt_inc >= acq_e) begin
                     state_d = ST_LOCKED;
                  end
               end
            end
            ST_LOCKED: begin
               if (!word_valid) begin
                  vcnt_d = '0;
                  if (err_inc >= lose_e) begin
                     state_d = ST_LOSS;
                     err_d   = '0;
                     pcnt_d  = '0;
                  end else begin
                     err_d = err_inc[CNT_W-1:0];
                  end
               end else if (vcnt_inc >= fgv_e) begin
                  vcnt_d = '0;
                  if (err_cnt != '0) begin
                     err_d = err_cnt - CNT_W'(1);
                  end
               end else begin
                  vcnt_d = vcnt_inc[CNT_W-1:0];
               end
            end
            default: state_d = ST_LOSS;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_LOSS;
         lock_off <= '0;
         pcnt     <= '0;
         err_cnt  <= '0;
         vcnt     <= '0;
      end else begin
         state_q  <= state_d;
         lock_off <= off_d;
         pcnt     <= pcnt_d;
         err_cnt  <= err_d;
         vcnt     <= vcnt_d;
      end
   end
endmodule

// File: rtl/wa_word_aligner.sv
// Top: history register, comma scan, framing and synchronization machine.
module wa_word_aligner
   import wa_pkg::*;
#(
   parameter int DATA_W    = 20,
   parameter int SYM_W     = 10,
   parameter int CNT_W     = 4,
   parameter bit BOTH_DISP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   input  logic [SYM_W-1:0]  comma_pat,
   input  logic [CNT_W-1:0]  acq_thr,
   input  logic [CNT_W-1:0]  lose_thr,
   input  logic [CNT_W-1:0]  fgv_thr,
   input  logic              realign,
   output logic [DATA_W-1:0] dout,
   output logic              pat_det,
   output logic              sync_ok
);
   localparam int OFF_W  = $clog2(DATA_W);
   localparam int HIST_W = 2 * DATA_W;
   localparam int SCAN_W = DATA_W + SYM_W - 1;
   localparam int PICK_W = HIST_W - 1;

   generate
      if ((DATA_W % SYM_W) != 0 || (DATA_W / SYM_W) < 2) begin : g_bad_width
         $error("DATA_W must hold two or more whole symbols");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] prev_q;
   logic [HIST_W-1:0] hist;
   logic              hit;
   logic [OFF_W-1:0]  hit_off;
   logic [DATA_W-1:0] aligned;
   logic              word_valid;
   logic              word_comma;
   wa_state_e         state_q;
   logic [OFF_W-1:0]  lock_off;
   logic [CNT_W-1:0]  err_cnt;

   assign hist = {din, prev_q};

   wa_comma_search #(
      .DATA_W    (DATA_W),
      .SYM_W     (SYM_W),
      .BOTH_DISP (BOTH_DISP),
      .OFF_W     (OFF_W),
      .SCAN_W    (SCAN_W)
   ) u_search (
      .scan    (hist[SCAN_W-1:0]),
      .pat     (comma_pat),
      .hit     (hit),
      .hit_off (hit_off)
   );

   wa_lane_pick #(
      .DATA_W    (DATA_W),
      .SYM_W     (SYM_W),
      .BOTH_DISP (BOTH_DISP),
      .OFF_W     (OFF_W),
      .PICK_W    (PICK_W)
   ) u_pick (
      .hist       (hist[PICK_W-1:0]),
      .off        (lock_off),
      .pat        (comma_pat),
      .aligned    (aligned),
      .word_valid (word_valid),
      .word_comma (word_comma)
   );

   wa_sync_fsm #(
      .OFF_W (OFF_W),
      .CNT_W (CNT_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .realign    (realign),
      .hit        (hit),
      .hit_off    (hit_off),
      .word_valid (word_valid),
      .word_comma (word_comma),
      .acq_thr    (acq_thr),
      .lose_thr   (lose_thr),
      .fgv_thr    (fgv_thr),
      .state_q    (state_q),
      .lock_off   (lock_off),
      .err_cnt    (err_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         dout    <= '0;
         pat_det <= 1'b0;
      end else begin
         prev_q  <= din;
         dout    <= aligned;
         pat_det <= word_comma;
      end
   end

   assign sync_ok = (state_q == ST_LOCKED);
endmodule

// File: rtl/wa_checker.sv
// Temporal checks for the word aligner, bound into every instance.
module wa_checker
   import wa_pkg::*;
#(
   parameter int DATA_W    = 20,
   parameter int SYM_W     = 10,
   parameter int CNT_W     = 4,
   parameter int OFF_W     = 5,
   parameter bit BOTH_DISP = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              realign,
   input logic              sync_ok,
   input logic              pat_det,
   input logic [DATA_W-1:0] dout,
   input logic [SYM_W-1:0]  comma_pat,
   input logic [CNT_W-1:0]  lose_thr,
   input logic              word_valid,
   input logic              word_comma,
   input logic              hit,
   input wa_state_e         state_q,
   input logic [OFF_W-1:0]  lock_off,
   input logic [CNT_W-1:0]  err_cnt
);
   localparam int LANES = DATA_W / SYM_W;

   logic           dout_has_comma;
   logic [CNT_W:0] lose_e;
   logic           last_error;

   always_comb begin
      dout_has_comma = 1'b0;
      for (int l = 0; l < LANES; l++) begin
         if (dout[l*SYM_W +: SYM_W] == comma_pat) dout_has_comma = 1'b1;
         if (BOTH_DISP && dout[l*SYM_W +: SYM_W] == ~comma_pat) dout_has_comma = 1'b1;
      end
   end

   assign lose_e     = (lose_thr == '0) ? (CNT_W+1)'(1) : {1'b0, lose_thr};
   assign last_error = ({1'b0, err_cnt} + (CNT_W+1)'(1)) >= lose_e;

   // R1
   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (!sync_ok && !pat_det && dout == '0));

   assert_patdet_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(comma_pat) |-> (pat_det == dout_has_comma));

   assert_lock_needs_comma_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_ok) |-> (($past(word_comma) || $past(hit)) && !$past(realign)));

   assert_hunt_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HUNT && !word_valid && !realign) |=> !sync_ok);

   assert_loss_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_ok && !word_valid && last_error) |=> !sync_ok);

   assert_realign_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      realign |=> !sync_ok);

   assert_offset_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_LOSS && !realign) |=> $stable(lock_off));
endmodule

bind wa_word_aligner wa_checker #(
   .DATA_W    (DATA_W),
   .SYM_W     (SYM_W),
   .CNT_W     (CNT_W),
   .OFF_W     (OFF_W),
   .BOTH_DISP (BOTH_DISP)
) u_wa_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .realign    (realign),
   .sync_ok    (sync_ok),
   .pat_det    (pat_det),
   .dout       (dout),
   .comma_pat  (comma_pat),
   .lose_thr   (lose_thr),
   .word_valid (word_valid),
   .word_comma (word_comma),
   .hit        (hit),
   .state_q    (state_q),
   .lock_off   (lock_off),
   .err_cnt    (err_cnt)
);

// File: tb/tb_wa_word_aligner.sv
module tb_wa_word_aligner;
   localparam logic [9:0] CPAT = 10'h17C;
   localparam logic [9:0] FIL  = 10'h2AA;
   localparam logic [9:0] BAD0 = 10'h000;
   localparam logic [9:0] BAD3 = 10'h007;
   localparam logic [9:0] BAD7 = 10'h3F8;
   localparam logic [9:0] G6   = 10'h33C;
   localparam logic [9:0] G4   = 10'h0C3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] din = '0;
   logic [9:0]  comma_pat = CPAT;
   logic [3:0]  acq_thr = 4'd3;
   logic [3:0]  lose_thr = 4'd4;
   logic [3:0]  fgv_thr = 4'd2;
   logic        realign = 1'b0;
   logic [19:0] dout;
   logic        pat_det;
   logic        sync_ok;

   always #5 clk = ~clk;

   wa_word_aligner dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .din       (din),
      .comma_pat (comma_pat),
      .acq_thr   (acq_thr),
      .lose_thr  (lose_thr),
      .fgv_thr   (fgv_thr),
      .realign   (realign),
      .dout      (dout),
      .pat_det   (pat_det),
      .sync_ok   (sync_ok)
   );

   int n_chk = 0;
   int n_bad = 0;
   int pd_seen = 0;
   bit done = 1'b0;
   bit q[$];

   // behavioural reference: state 0 loss, 1 hunt, 2 locked
   logic [19:0] m_prev = '0;
   logic [19:0] m_dout = '0;
   logic        m_pd = 1'b0;
   int          m_st = 0, m_off = 0, m_pc = 0, m_ec = 0, m_vc = 0;

   function automatic bit is_comma(logic [9:0] s);
      return (s == comma_pat) || (s == ~comma_pat);
   endfunction

   function automatic bit is_legal(logic [9:0] s);
      int c = $countones(s);
      return (c >= 4) && (c <= 6);
   endfunction

   function automatic int eff(logic [3:0] t);
      return (t == 4'd0) ? 1 : int'(t);
   endfunction

   always @(posedge clk) begin : ref_model
      logic [39:0] h;
      logic [19:0] aw;
      bit          v, hit;
      int          hk;
      if (!rst_n) begin
         m_prev = '0; m_dout = '0; m_pd = 1'b0;
         m_st = 0; m_off = 0; m_pc = 0; m_ec = 0; m_vc = 0;
      end else begin
         h   = {din, m_prev};
         aw  = h[m_off +: 20];
         v   = is_legal(aw[9:0]) && is_legal(aw[19:10]);
         hit = 1'b0;
         hk  = 0;
         for (int k = 19; k >= 0; k--) begin
            if (is_comma(h[k +: 10])) begin hit = 1'b1; hk = k; end
         end
         m_dout = aw;
         m_pd   = is_comma(aw[9:0]) || is_comma(aw[19:10]);
         m_prev = din;
         if (realign) begin
            m_st = 0; m_pc = 0; m_ec = 0; m_vc = 0;
         end else if (m_st == 0) begin
            if (hit) begin
               m_off = hk; m_pc = 1; m_ec = 0; m_vc = 0;
               m_st = (eff(acq_thr) <= 1) ? 2 : 1;
            end
         end else if (m_st == 1) begin
            if (!v) begin
               m_st = 0; m_pc = 0;
            end else if (m_pd) begin
               m_pc++;
               if (m_pc >= eff(acq_thr)) m_st = 2;
            end
         end else begin
            if (!v) begin
               m_vc = 0;
               if (m_ec + 1 >= eff(lose_thr)) begin
                  m_st = 0; m_ec = 0; m_pc = 0;
               end else m_ec++;
            end else if (m_vc + 1 >= eff(fgv_thr)) begin
               m_vc = 0;
               if (m_ec > 0) m_ec--;
            end else m_vc++;
         end
      end
   end

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic push_sym(logic [9:0] s);
      for (int i = 0; i < 10; i++) q.push_back(s[i]);
   endtask

   task automatic push_pair(logic [9:0] lo, logic [9:0] hi);
      push_sym(lo);
      push_sym(hi);
   endtask

   // one clock: compare at the falling edge, then drive the next word
   task automatic step();
      @(negedge clk);
      check(dout == m_dout, "R3", "aligned data", int'(dout), int'(m_dout));
      check(pat_det == m_pd, "R4", "pattern detect", int'(pat_det), int'(m_pd));
      check(sync_ok == (m_st == 2), "R5", "sync flag", int'(sync_ok), int'(m_st == 2));
      if (pat_det) pd_seen++;
      if (q.size() < 20) push_pair(FIL, FIL);
      for (int i = 0; i < 20; i++) din[i] = q.pop_front();
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL R5 watchdog: actual %0h expected %0h", 0, 1);
      finish_up();
   end

   initial begin
      // R1: reset state
      run(3);
      check(dout == '0 && !pat_det && !sync_ok, "R1", "reset outputs",
            int'({sync_ok, pat_det}), 0);
      rst_n = 1'b1;

      // R6: a bad word during hunt restarts acquisition
      for (int i = 0; i < 7; i++) q.push_back(i[0]);
      push_pair(CPAT, FIL);
      push_pair(BAD0, BAD0);
      push_pair(CPAT, FIL);
      push_pair(CPAT, FIL);
      run(9);
      check(!sync_ok, "R6", "no lock after bad word in hunt", int'(sync_ok), 0);

      // R5, R4: third comma completes acquisition, one detect pulse
      pd_seen = 0;
      push_pair(CPAT, FIL);
      run(6);
      check(sync_ok, "R5", "locked after acquire count", int'(sync_ok), 1);
      check(pd_seen == 1, "R4", "detect pulses", pd_seen, 1);

      // R10: commas slipped by two bits do not move the boundary
      lose_thr = 4'd15;
      pd_seen = 0;
      q.push_back(1'b0);
      q.push_back(1'b1);
      push_pair(CPAT, FIL);
      push_pair(FIL, FIL);
      push_pair(CPAT, FIL);
      push_pair(FIL, FIL);
      push_pair(CPAT, FIL);
      run(10);
      check(pd_seen == 0, "R10", "detects at foreign offset", pd_seen, 0);
      check(sync_ok, "R10", "lock kept", int'(sync_ok), 1);

      // R7: a run of bad words drops lock
      lose_thr = 4'd4;
      for (int i = 0; i < 6; i++) push_pair(BAD0, BAD0);
      run(10);
      check(!sync_ok, "R7", "lock lost", int'(sync_ok), 0);

      // R2: complement commas acquire lock
      for (int i = 0; i < 3; i++) push_pair(~CPAT, FIL);
      run(8);
      check(sync_ok, "R2", "lock on complement comma", int'(sync_ok), 1);

      // R9: realign drops lock on the next edge
      realign = 1'b1;
      step();
      check(!sync_ok, "R9", "sync after realign", int'(sync_ok), 0);
      realign = 1'b0;
      run(3);

      // R8, R11: forgiveness keeps lock through scattered bad words
      for (int i = 0; i < 3; i++) push_pair(CPAT, FIL);
      run(7);
      check(sync_ok, "R5", "relocked", int'(sync_ok), 1);
      for (int i = 0; i < 5; i++) begin
         push_pair(FIL, BAD3);
         push_pair(G6, G4);
         push_pair(FIL, FIL);
      end
      run(19);
      check(sync_ok, "R8", "lock held by forgiveness", int'(sync_ok), 1);
      check(m_ec == 0, "R11", "4 and 6 ones legal", m_ec, 0);

      // R8: runs shorter than the forgive count do not help
      push_pair(FIL, BAD3);
      push_pair(G6, G4);
      push_pair(FIL, BAD7);
      push_pair(G6, G4);
      push_pair(FIL, BAD3);
      push_pair(FIL, BAD7);
      run(10);
      check(!sync_ok, "R8", "lock lost without full runs", int'(sync_ok), 0);

      finish_up();
   end
endmodule